// File: doc/BRIEF.md
# SPI Master with Split-Edge MISO Sampling

This block is an SPI master that exchanges one 16-bit word per transfer with a single slave. The polarity and phase of the serial clock are chosen per transfer from a 3-bit mode value. Bits 1 and 0 use the usual SPI numbering. Bit 2 moves the MISO sampling point to the other SCLK edge and leaves the MOSI launch edge where it was. With this bit the master can serve a slave built around one shift register for both directions. Such a slave takes in MOSI and pushes out its next MISO bit on the same edge. Mode 5 is the typical setting for that kind of slave: idle-low clock, with MOSI launched and MISO sampled on every rising edge.

The host loads a word and a mode, sets a half-period divider and pulses a start strobe. Busy stays high through the transfer. When busy drops, the received word appears together with a single-cycle valid strobe. MISO reaches the system clock domain through a synchronizer. Each sample is taken from the synchronized stream at the point that matches the MISO level in the system cycle of the chosen SCLK edge. Because of that, the shortest half-period of one system cycle still works.

Top module: `spi_split_master`

## Requirements
- R1: A transfer moves exactly 16 bits each way, MSB first. Afterwards the slave holds the transmitted word and rx_data_o holds the word the slave sent.
- R2: mode_i[1] sets the SCLK idle level (1 = idle high). While the block is idle, sclk_o follows mode_i[1] one cycle later, so mode_i must be held for at least one cycle before start_i.
- R3: With mode_i[0]=0, MOSI shows bit 15 from the cycle chip select falls, later bits change on trailing edges, and MISO is sampled on leading edges. With mode_i[0]=1, every bit is launched on a leading edge (MOSI is 0 before the first edge) and MISO is sampled on trailing edges.
- R4: With mode_i[2]=1, MISO is sampled on the edge opposite the one R3 gives, and MOSI timing is unchanged. For example, mode 5 launches and samples on rising edges.
- R5: Each SCLK half-period lasts div_i+1 system cycles. Chip select falls div_i+1 cycles before the first edge and rises div_i+1 cycles after the last one. Exactly 32 SCLK edges occur while chip select is low.
- R6: At the end of a transfer busy_o falls in the same cycle that rx_valid_o pulses high for exactly one cycle, and rx_data_o holds the word from then on.
- R7: A start_i pulse while busy_o is high has no effect: the running transfer keeps its word and mode, and no second transfer follows.
- R8: MISO passes through a two-stage synchronizer. Each sample still takes the MISO level present in the system cycle of its SCLK edge, so transfers are correct with div_i=0.
- R9: After reset, cs_no is 1, and busy_o, rx_valid_o, sclk_o, mosi_o and rx_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| tx_data_i | input | 16 | Word to send |
| mode_i | input | 3 | {sample swap, polarity, phase} |
| div_i | input | 8 | Half-period length minus one, in system cycles |
| busy_o | output | 1 | Transfer in progress |
| rx_data_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe when rx_data_o updates |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
A slip in the edge counter or in the leading/trailing decode shows up at the pins straight away. SCLK ends at the wrong level, or a count other than 32 edges falls inside chip select, and the trailing half-period comes out with the wrong length. Picking the wrong sample edge, or the wrong delay for the synchronizer, does not disturb the pins during the transfer. It appears only as a shifted received word when valid pulses. For that reason a bench slave is set up so that its bits change on the edge the master must avoid. A latch that takes a start while busy would show as a changed word, or as a second valid strobe, within one transfer time.

// File: rtl/spi_split_pkg.sv
`timescale 1ns/1ps
package spi_split_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TAIL,
    ST_FLUSH
  } state_t;

  // bit order matches mode_i[2:0]
  typedef struct packed {
    logic swap;
    logic cpol;
    logic cpha;
  } mode_t;
endpackage

// File: rtl/spi_half_timer.sv
`timescale 1ns/1ps
module spi_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_bit_delay.sv
`timescale 1ns/1ps
// STAGES-deep flop chain; used as MISO synchronizer and as sample-strobe delay
module spi_bit_delay #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic any_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o   = ff_q[STAGES-1];
  assign any_o = |ff_q;
endmodule

// File: rtl/spi_split_master.sv
`timescale 1ns/1ps
module spi_split_master
  import spi_split_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic [2:0]        mode_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  localparam int unsigned EDGES  = 2 * WORD_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);

  state_t            state_q;
  mode_t             mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_data_q;
  logic              sclk_q, mosi_q, cs_nq, rx_valid_q;

  logic run, tick, edge_fire, leading, last_edge;
  logic launch_now, sample_now, miso_s, take, pipe_busy, unused_sync_any;

  assign run        = (state_q == ST_LEAD) || (state_q == ST_RUN) || (state_q == ST_TAIL);
  assign edge_fire  = tick && ((state_q == ST_LEAD) || (state_q == ST_RUN));
  assign leading    = ~edge_q[0];
  assign last_edge  = (edge_q == EDGE_W'(EDGES - 1));
  // phase 0: first bit preloaded, rest on trailing edges; phase 1: all on leading
  assign launch_now = edge_fire && (mode_q.cpha ? leading : (!leading && !last_edge));
  // standard sampling is leading for phase 0; swap bit inverts it
  assign sample_now = edge_fire && (leading == ~(mode_q.cpha ^ mode_q.swap));

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_bit_delay #(.STAGES(SYNC_STAGES)) u_miso_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (miso_i),
    .q_o    (miso_s),
    .any_o  (unused_sync_any)
  );

  // strobe delayed by the synchronizer depth so it meets the edge-time MISO value
  spi_bit_delay #(.STAGES(SYNC_STAGES)) u_sample_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sample_now),
    .q_o    (take),
    .any_o  (pipe_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      div_q      <= '0;
      edge_q     <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      rx_data_q  <= '0;
      sclk_q     <= 1'b0;
      mosi_q     <= 1'b0;
      cs_nq      <= 1'b1;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (take) rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_s};
      case (state_q)
        ST_IDLE: begin
          sclk_q <= mode_i[1];
          mosi_q <= 1'b0;
          cs_nq  <= 1'b1;
          if (start_i) begin
            mode_q  <= mode_t'(mode_i);
            div_q   <= div_i;
            edge_q  <= '0;
            rx_sh_q <= '0;
            cs_nq   <= 1'b0;
            state_q <= ST_LEAD;
            if (mode_i[0]) begin
              tx_sh_q <= tx_data_i;
            end else begin
              mosi_q  <= tx_data_i[WORD_W-1];
              tx_sh_q <= {tx_data_i[WORD_W-2:0], 1'b0};
            end
          end
        end
        ST_LEAD, ST_RUN: begin
          if (edge_fire) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            if (launch_now) begin
              mosi_q  <= tx_sh_q[WORD_W-1];
              tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
            end
            state_q <= last_edge ? ST_TAIL : ST_RUN;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_nq   <= 1'b1;
            state_q <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (!pipe_busy) begin
            rx_data_q  <= rx_sh_q;
            rx_valid_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = mosi_q;
  assign cs_no      = cs_nq;
endmodule

// File: rtl/spi_split_master_chk.sv
`timescale 1ns/1ps
module spi_split_master_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       busy_o,
  input logic       rx_valid_o,
  input logic       cs_no,
  input logic       sclk_o,
  input logic [2:0] mode_q
);
  localparam int unsigned EDGES = 2 * WORD_W;
  localparam int unsigned CNT_W = $clog2(EDGES + 1);

  logic             sclk_d;
  logic [CNT_W-1:0] edge_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      edge_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_no)                 edge_cnt <= '0;
      else if (sclk_o != sclk_d) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  p_edge_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> edge_cnt == CNT_W'(EDGES));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_busy_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> rx_valid_o);

  p_idle_sclk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && $past(rst_ni)) |-> sclk_o == $past(mode_i[1]));

  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mode_q));
endmodule

bind spi_split_master spi_split_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .busy_o     (busy_o),
  .rx_valid_o (rx_valid_o),
  .cs_no      (cs_no),
  .sclk_o     (sclk_o),
  .mode_q     (mode_q)
);

// File: tb/spi_split_master_tb.sv
`timescale 1ns/1ps
module spi_split_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tx = '0;
  logic [2:0]  mode = '0;
  logic [7:0]  div = '0;
  logic        miso = 1'b0;
  logic        busy, rx_valid, sclk, mosi, cs_n;
  logic [15:0] rx_data;

  always #5 clk = ~clk;

  spi_split_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_data_i(tx),
    .mode_i(mode), .div_i(div), .busy_o(busy), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .cs_no(cs_n)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // slave model: edges chosen per mode so bits change on the edge the master must avoid
  logic        s_drive_rise = 1'b0, s_cap_rise = 1'b1, s_preload = 1'b1;
  logic [15:0] s_word = '0, s_out = '0, s_in = '0;
  logic        last_sclk = 1'b0;

  always @(negedge cs_n or posedge sclk or negedge sclk) begin
    if (sclk !== last_sclk) begin
      if (!cs_n) begin
        if (sclk == s_cap_rise) s_in = {s_in[14:0], mosi};
        if (sclk == s_drive_rise) begin
          miso  = s_out[15];
          s_out = s_out << 1;
        end
      end
    end else if (!cs_n) begin
      s_in = '0;
      if (s_preload) begin
        miso  = s_word[15];
        s_out = s_word << 1;
      end else begin
        miso  = 1'b0;
        s_out = s_word;
      end
    end
    last_sclk = sclk;
  end

  // pin monitor
  logic p_cs = 1'b1, p_sclk = 1'b0, mosi_at_cs = 1'b0;
  bit   lead_on = 1'b0;
  int   lead_n = 0, lead_rec = 0, tail_n = 0, tail_rec = 0, edges_n = 0, valid_n = 0;

  always @(negedge clk) begin
    if (rx_valid) valid_n++;
    if (p_cs && !cs_n) begin
      lead_n = 1; lead_on = 1'b1; edges_n = 0; tail_n = 0; mosi_at_cs = mosi;
    end else if (!cs_n) begin
      if (sclk !== p_sclk) begin
        if (lead_on) begin lead_rec = lead_n; lead_on = 1'b0; end
        edges_n++;
        tail_n = 0;
      end else begin
        if (lead_on) lead_n++;
        tail_n++;
      end
    end else if (!p_cs && cs_n) begin
      tail_rec = tail_n + 1;
    end
    p_cs = cs_n;
    p_sclk = sclk;
  end

  task automatic set_slave(input logic [2:0] m, input logic [15:0] w);
    logic samp_lead;
    samp_lead    = ~(m[0] ^ m[2]);
    s_preload    = samp_lead;
    s_drive_rise = (~samp_lead) ^ m[1];
    s_cap_rise   = (~m[0]) ^ m[1];
    s_word       = w;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (rx_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_xfer(input logic [2:0] m, input logic [7:0] d, input logic [15:0] t, input logic [15:0] w);
    bit got;
    string tag;
    set_slave(m, w);
    @(negedge clk);
    mode = m; div = d; tx = t;
    repeat (2) @(negedge clk);
    pulse_start();
    wait_valid(got);
    chk(got, "R6 valid seen", 32'(got), 32'd1);
    chk(busy == 1'b0, "R6 busy low at valid", 32'(busy), 32'd0);
    tag = m[2] ? "R4 rx word" : ((d == 8'd0) ? "R8 rx word" : "R1 rx word");
    chk(rx_data == w, tag, 32'(rx_data), 32'(w));
    chk(s_in == t, "R1 slave got tx", 32'(s_in), 32'(t));
    chk(mosi_at_cs == (m[0] ? 1'b0 : t[15]), "R3 mosi at cs fall", 32'(mosi_at_cs), 32'(m[0] ? 1'b0 : t[15]));
    chk(lead_rec == int'(d) + 1, "R5 lead cycles", 32'(lead_rec), 32'(int'(d) + 1));
    chk(tail_rec == int'(d) + 1, "R5 tail cycles", 32'(tail_rec), 32'(int'(d) + 1));
    chk(edges_n == 32, "R5 edge count", 32'(edges_n), 32'd32);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R6 valid one cycle", 32'(rx_valid), 32'd0);
    chk(rx_data == w, "R6 rx held", 32'(rx_data), 32'(w));
    chk(sclk == m[1], "R2 idle level", 32'(sclk), 32'(m[1]));
  endtask

  // {mode, div, tx, slave word}
  localparam logic [42:0] VEC [8] = '{
    {3'd0, 8'd0, 16'hA5C3, 16'h3C96},
    {3'd1, 8'd1, 16'h1234, 16'hFEDC},
    {3'd2, 8'd2, 16'h8001, 16'h7FFE},
    {3'd3, 8'd0, 16'hFFFF, 16'h0000},
    {3'd4, 8'd1, 16'h0F0F, 16'h9A5B},
    {3'd5, 8'd0, 16'hC0DE, 16'hBEEF},
    {3'd6, 8'd3, 16'h5555, 16'hAAAA},
    {3'd7, 8'd2, 16'h0001, 16'h8001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R6 act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit got;
    int v0;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R9 cs high", 32'(cs_n), 32'd1);
    chk(busy == 1'b0, "R9 busy low", 32'(busy), 32'd0);
    chk(rx_valid == 1'b0, "R9 valid low", 32'(rx_valid), 32'd0);
    chk(sclk == 1'b0, "R9 sclk low", 32'(sclk), 32'd0);
    chk(mosi == 1'b0, "R9 mosi low", 32'(mosi), 32'd0);
    chk(rx_data == 16'h0, "R9 rx zero", 32'(rx_data), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 idle level follows polarity bit
    mode = 3'b010;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R2 idle follows high", 32'(sclk), 32'd1);
    mode = 3'b000;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R2 idle follows low", 32'(sclk), 32'd0);

    foreach (VEC[i]) begin
      run_xfer(VEC[i][42:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0]);
    end

    // R7 start while busy is ignored
    set_slave(3'd0, 16'h2468);
    @(negedge clk);
    mode = 3'd0; div = 8'd2; tx = 16'h1357;
    repeat (2) @(negedge clk);
    v0 = valid_n;
    pulse_start();
    repeat (12) @(negedge clk);
    tx = 16'hFFFF;
    pulse_start();
    tx = 16'h1357;
    wait_valid(got);
    chk(rx_data == 16'h2468, "R7 rx unaffected", 32'(rx_data), 32'h2468);
    chk(s_in == 16'h1357, "R7 tx unaffected", 32'(s_in), 32'h1357);
    repeat (60) @(negedge clk);
    chk(valid_n - v0 == 1, "R7 single transfer", 32'(valid_n - v0), 32'd1);
    chk(cs_n == 1'b1 && busy == 1'b0, "R7 no restart", 32'({cs_n, busy}), 32'b10);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule